// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Event Unit

This block collects a parameterized set of level-sensitive hardware interrupt lines and presents them to a small number of CPUs. Each CPU has its own register access port. A CPU services interrupts by reading its event register. The read returns the lowest-numbered line that is pending, unmasked and routed to that CPU. The same read acknowledges the line by setting its mask bit. After servicing, software unmasks the line explicitly.

Software can force any line pending through a set of software-trigger bits. These bits are ORed with the hardware input. Each line has a routing word that holds a bitmap of the CPUs allowed to take it. Each CPU has an interrupt output. It stays high while that CPU has any eligible line.

Top module: `aic_event_unit`

## Requirements
- R1: After reset, every mask bit reads 1, every software-trigger bit reads 0, every routing word reads 1 (CPU 0 only), all interrupt outputs are low, and an event read returns 0.
- R2: An event read at 0x2004 returns type 1 in bits 31:16 and the line number in bits 15:0. When the CPU has no eligible line, it returns 0.
- R3: Among the eligible lines of a CPU, the event read returns the lowest-numbered one.
- R4: An event read that returns a line sets that line's mask bit at the next clock edge. The CPU's interrupt output falls at that edge if no other eligible line remains.
- R5: The mask bits are changed by writing 1 bits to the set bank at 0x4100 or the clear bank at 0x4180. Line n sits in the word at offset 4*(n>>5), at bit n&31. Zero bits have no effect. Reading either bank returns the current mask word.
- R6: The software-trigger bits are set through the bank at 0x4000 and cleared through the bank at 0x4080, using the same word and bit layout. A set bit makes its line pending exactly as a high hardware input does. Reading either bank returns the current trigger word.
- R7: The routing word of line n is at 0x3000+4*n. Bit c of this word makes the line eligible at CPU c only.
- R8: The register at 0x0004 returns the number of lines. The register at 0x2000 returns the index of the CPU port that reads it.
- R9: Two CPUs may read the event register in the same cycle while a line is routed to both. The lower-numbered CPU then receives that line, and the other CPU receives its next eligible line.
- R10: A CPU's interrupt output is high exactly while at least one line is pending, unmasked and routed to that CPU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_irq | input | NUM_LINES | Level-sensitive hardware interrupt lines |
| cpu_req | input | NUM_CPUS | Access strobe, one per CPU port |
| cpu_we | input | NUM_CPUS | 1 = write, 0 = read, one per CPU port |
| cpu_addr | input | NUM_CPUS*16 | Byte address, 16 bits per CPU port |
| cpu_wdata | input | NUM_CPUS*32 | Write data, 32 bits per CPU port |
| cpu_rdata | output | NUM_CPUS*32 | Read data, valid in the same cycle as a read strobe |
| cpu_irq | output | NUM_CPUS | Interrupt request, one per CPU |

## Verification
A wrong mask or trigger bit shows up on the next read of its bank. It also shows up at once on the interrupt output of any CPU that the line is routed to. A broken priority chain or a broken same-cycle arbitration shows up in the line number returned by that very event read. A missing auto-acknowledge leaves the interrupt output high after the clock edge that follows the read, and the next event read returns the same line again.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_LINES  = 16'h0004;
  localparam logic [ADDR_W-1:0] A_SELF   = 16'h2000;
  localparam logic [ADDR_W-1:0] A_EVENT  = 16'h2004;

  // Upper address bits [15:7] select a 32-word bank
  localparam logic [8:0] BK_TRIG_SET = 9'h080;
  localparam logic [8:0] BK_TRIG_CLR = 9'h081;
  localparam logic [8:0] BK_MASK_SET = 9'h082;
  localparam logic [8:0] BK_MASK_CLR = 9'h083;
  // Upper address bits [15:12] select the routing words
  localparam logic [3:0] RT_HI = 4'h3;

  localparam logic [15:0] EVT_KIND_HW = 16'd1;
endpackage

// File: rtl/aic_state.sv
module aic_state
  import aic_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2,
  localparam int WORDS = (NUM_LINES + 31) / 32,
  localparam int WBITS = WORDS * 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CPUS-1:0]           wr_en,
  input  logic [NUM_CPUS*ADDR_W-1:0]    addr,
  input  logic [NUM_CPUS*DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0]          ack,
  output logic [WBITS-1:0]              mask_o,
  output logic [WBITS-1:0]              trig_o,
  output logic [NUM_LINES*NUM_CPUS-1:0] route_o
);
  logic [WBITS-1:0] mask_q, mask_d, trig_q, trig_d;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_q, route_d;
  logic upd_en;

  assign upd_en = (|wr_en) | (|ack);

  // Next state: writes are applied from the highest CPU down, so the lower
  // CPU wins a routing conflict; the acknowledge mask is applied last.
  always_comb begin
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    mask_d  = mask_q;
    trig_d  = trig_q;
    route_d = route_q;
    for (int c = NUM_CPUS - 1; c >= 0; c--) begin
      a = addr[c*ADDR_W +: ADDR_W];
      d = wdata[c*DATA_W +: DATA_W];
      if (wr_en[c]) begin
        for (int w = 0; w < WORDS; w++) begin
          if (a[6:2] == 5'(w)) begin
            case (a[15:7])
              BK_TRIG_SET: trig_d[w*32 +: 32] = trig_d[w*32 +: 32] | d;
              BK_TRIG_CLR: trig_d[w*32 +: 32] = trig_d[w*32 +: 32] & ~d;
              BK_MASK_SET: mask_d[w*32 +: 32] = mask_d[w*32 +: 32] | d;
              BK_MASK_CLR: mask_d[w*32 +: 32] = mask_d[w*32 +: 32] & ~d;
              default: ;
            endcase
          end
        end
        if (a[15:12] == RT_HI) begin
          for (int n = 0; n < NUM_LINES; n++) begin
            if (a[11:2] == 10'(n)) route_d[n] = d[NUM_CPUS-1:0];
          end
        end
      end
    end
    mask_d = mask_d | WBITS'(ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
      for (int n = 0; n < NUM_LINES; n++) route_q[n] <= NUM_CPUS'(1);
    end else if (upd_en) begin
      mask_q  <= mask_d;
      trig_q  <= trig_d;
      route_q <= route_d;
    end
  end

  assign mask_o  = mask_q;
  assign trig_o  = trig_q;
  assign route_o = route_q;
endmodule

// File: rtl/aic_pick.sv
module aic_pick #(
  parameter int NUM_LINES = 64,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] cand,
  output logic                 found,
  output logic [LW-1:0]        idx
);
  // Lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int n = NUM_LINES - 1; n >= 0; n--) begin
      if (cand[n]) begin
        found = 1'b1;
        idx   = LW'(n);
      end
    end
  end
endmodule

// File: rtl/aic_event_unit.sv
module aic_event_unit
  import aic_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       hw_irq,
  input  logic [NUM_CPUS-1:0]        cpu_req,
  input  logic [NUM_CPUS-1:0]        cpu_we,
  input  logic [NUM_CPUS*ADDR_W-1:0] cpu_addr,
  input  logic [NUM_CPUS*DATA_W-1:0] cpu_wdata,
  output logic [NUM_CPUS*DATA_W-1:0] cpu_rdata,
  output logic [NUM_CPUS-1:0]        cpu_irq
);
  localparam int WORDS = (NUM_LINES + 31) / 32;
  localparam int WBITS = WORDS * 32;
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [WBITS-1:0]              mask_q, trig_q;
  logic [NUM_LINES*NUM_CPUS-1:0] route_q;
  logic [NUM_LINES-1:0]          pend, open_lines, ack;
  logic [NUM_CPUS:0][NUM_LINES-1:0] avail;

  assign pend       = hw_irq | trig_q[NUM_LINES-1:0];
  assign open_lines = pend & ~mask_q[NUM_LINES-1:0];
  assign avail[0]   = '1;
  assign ack        = ~avail[NUM_CPUS];

  aic_state #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_state (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cpu_req & cpu_we),
    .addr   (cpu_addr),
    .wdata  (cpu_wdata),
    .ack    (ack),
    .mask_o (mask_q),
    .trig_o (trig_q),
    .route_o(route_q)
  );

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
    logic [NUM_LINES-1:0] routed, elig;
    logic                 found, evt_rd, take;
    logic [LW-1:0]        idx;
    logic [ADDR_W-1:0]    a;
    logic [DATA_W-1:0]    rd;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_col
      assign routed[n] = route_q[n*NUM_CPUS + g];
    end

    assign elig   = open_lines & routed;
    assign a      = cpu_addr[g*ADDR_W +: ADDR_W];
    assign evt_rd = cpu_req[g] & ~cpu_we[g] & (a == A_EVENT);
    assign take   = evt_rd & found;
    assign cpu_irq[g] = |elig;

    aic_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .cand (elig & avail[g]),
      .found(found),
      .idx  (idx)
    );

    assign avail[g+1] = avail[g] & ~(take ? (NUM_LINES'(1) << idx) : '0);

    always_comb begin
      rd = '0;
      if (cpu_req[g] && !cpu_we[g]) begin
        if (a == A_LINES)       rd = DATA_W'(NUM_LINES);
        else if (a == A_SELF)   rd = DATA_W'(g);
        else if (a == A_EVENT)  rd = found ? {EVT_KIND_HW, 16'(idx)} : '0;
        else if (a[15:7] == BK_TRIG_SET || a[15:7] == BK_TRIG_CLR) begin
          for (int w = 0; w < WORDS; w++)
            if (a[6:2] == 5'(w)) rd = trig_q[w*32 +: 32];
        end else if (a[15:7] == BK_MASK_SET || a[15:7] == BK_MASK_CLR) begin
          for (int w = 0; w < WORDS; w++)
            if (a[6:2] == 5'(w)) rd = mask_q[w*32 +: 32];
        end else if (a[15:12] == RT_HI) begin
          for (int n = 0; n < NUM_LINES; n++)
            if (a[11:2] == 10'(n)) rd = DATA_W'(route_q[n*NUM_CPUS +: NUM_CPUS]);
        end
      end
    end
    assign cpu_rdata[g*DATA_W +: DATA_W] = rd;
  end
endmodule

// File: rtl/aic_event_unit_chk.sv
module aic_event_unit_chk
  import aic_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 2,
  localparam int WBITS = ((NUM_LINES + 31) / 32) * 32,
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CPUS-1:0]        cpu_req,
  input logic [NUM_CPUS-1:0]        cpu_we,
  input logic [NUM_CPUS*ADDR_W-1:0] cpu_addr,
  input logic [NUM_CPUS*DATA_W-1:0] cpu_rdata,
  input logic [WBITS-1:0]           mask
);
  logic [NUM_CPUS-1:0] evt, self_rd, clr_wr;

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_c
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] r;
    assign a = cpu_addr[g*ADDR_W +: ADDR_W];
    assign r = cpu_rdata[g*DATA_W +: DATA_W];
    assign evt[g]     = cpu_req[g] & ~cpu_we[g] & (a == A_EVENT);
    assign self_rd[g] = cpu_req[g] & ~cpu_we[g] & (a == A_SELF);
    assign clr_wr[g]  = cpu_req[g] & cpu_we[g] & (a[15:7] == BK_MASK_CLR);

    // R2
    evt_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |-> (r == '0) || (r[31:16] == EVT_KIND_HW && r[15:0] < 16'(NUM_LINES)));

    // R4
    evt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && r[31:16] == EVT_KIND_HW) |=> mask[$past(r[LW-1:0])]);

    // R8
    self_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_rd[g] |-> (r == DATA_W'(g)));
  end

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|clr_wr) |=> ((mask & $past(mask)) == $past(mask)));

  if (NUM_CPUS > 1) begin : g_pair
    // R9
    dual_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[0] && evt[1] && cpu_rdata[31:16] == EVT_KIND_HW &&
       cpu_rdata[DATA_W+31:DATA_W+16] == EVT_KIND_HW)
      |-> cpu_rdata[15:0] != cpu_rdata[DATA_W+15:DATA_W]);
  end
endmodule

bind aic_event_unit aic_event_unit_chk #(
  .NUM_LINES(NUM_LINES),
  .NUM_CPUS (NUM_CPUS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cpu_req  (cpu_req),
  .cpu_we   (cpu_we),
  .cpu_addr (cpu_addr),
  .cpu_rdata(cpu_rdata),
  .mask     (mask_q)
);

// File: tb/aic_event_unit_tb.sv
`timescale 1ns/1ps
module aic_event_unit_tb;
  localparam int L = 64;
  localparam int C = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [L-1:0]  hw_irq;
  logic [C-1:0]  req, we;
  logic [C*16-1:0] addr;
  logic [C*32-1:0] wdata, rdata;
  logic [C-1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  aic_event_unit #(.NUM_LINES(L), .NUM_CPUS(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
    .cpu_req(req), .cpu_we(we), .cpu_addr(addr), .cpu_wdata(wdata),
    .cpu_rdata(rdata), .cpu_irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input int c, input bit w, input logic [15:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c*16 +: 16] = a; wdata[c*32 +: 32] = d;
    #1 r = rdata[c*32 +: 32];
    @(posedge clk);
    #1 req[c] = 1'b0; we[c] = 1'b0;
  endtask

  task automatic wr(input int c, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(c, 1'b1, a, d, r);
  endtask

  task automatic rd(input int c, input logic [15:0] a, output logic [31:0] r);
    acc(c, 1'b0, a, 32'h0, r);
  endtask

  task automatic unmask(input int n);
    wr(0, 16'h4180 + 16'(4 * (n >> 5)), 32'(1) << (n & 31));
  endtask

  task automatic cleanup();
    hw_irq = '0;
    wr(0, 16'h4100, 32'hFFFF_FFFF); wr(0, 16'h4104, 32'hFFFF_FFFF);
    wr(0, 16'h4080, 32'hFFFF_FFFF); wr(0, 16'h4084, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(0, 16'h4100, r); chk("R1 mask w0", r, 32'hFFFF_FFFF);
    rd(1, 16'h4184, r); chk("R1 mask w1", r, 32'hFFFF_FFFF);
    rd(0, 16'h4000, r); chk("R1 trig w0", r, 32'h0);
    rd(0, 16'h3000 + 16'd20, r); chk("R1 route line5", r, 32'h1);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(0, 16'h2004, r); chk("R1 R2 empty event", r, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] r;
    rd(0, 16'h0004, r); chk("R8 line count", r, 32'd64);
    rd(0, 16'h2000, r); chk("R8 self cpu0", r, 32'd0);
    rd(1, 16'h2000, r); chk("R8 self cpu1", r, 32'd1);
  endtask

  task automatic t_basic();
    logic [31:0] r;
    hw_irq[10] = 1'b1;
    #1 chk("R10 masked no irq", 32'(irq), 32'h0);
    unmask(10);
    chk("R10 irq cpu0 only", 32'(irq), 32'h1);
    rd(0, 16'h2004, r); chk("R2 event word", r, 32'h0001_000A);
    chk("R4 irq fell", 32'(irq), 32'h0);
    rd(0, 16'h4100, r); chk("R4 mask set by read", r, 32'hFFFF_FFFF);
    rd(0, 16'h2004, r); chk("R4 R2 no repeat", r, 32'h0);
    cleanup();
  endtask

  task automatic t_mask();
    logic [31:0] r;
    wr(1, 16'h4100, 32'h0);
    rd(0, 16'h4180, r); chk("R5 zero set no effect", r, 32'hFFFF_FFFF);
    wr(0, 16'h4180, 32'h8);
    rd(0, 16'h4100, r); chk("R5 clear bit3", r, 32'hFFFF_FFF7);
    wr(0, 16'h4180, 32'h0);
    rd(0, 16'h4100, r); chk("R5 zero clear no effect", r, 32'hFFFF_FFF7);
    wr(1, 16'h4184, 32'h100);
    rd(0, 16'h4104, r); chk("R5 clear line40", r, 32'hFFFF_FEFF);
    rd(0, 16'h4100, r); chk("R5 word0 untouched", r, 32'hFFFF_FFF7);
    wr(0, 16'h4100, 32'h8);
    rd(0, 16'h4100, r); chk("R5 set bit3", r, 32'hFFFF_FFFF);
    cleanup();
  endtask

  task automatic t_prio();
    logic [31:0] r;
    hw_irq[40] = 1'b1; hw_irq[7] = 1'b1; hw_irq[33] = 1'b1;
    unmask(40); unmask(33); unmask(7);
    rd(0, 16'h2004, r); chk("R3 first line7", r, 32'h0001_0007);
    chk("R10 irq still high", 32'(irq), 32'h1);
    rd(0, 16'h2004, r); chk("R3 second line33", r, 32'h0001_0021);
    rd(0, 16'h2004, r); chk("R3 third line40", r, 32'h0001_0028);
    chk("R4 irq low after last", 32'(irq), 32'h0);
    rd(0, 16'h2004, r); chk("R3 R2 drained", r, 32'h0);
    cleanup();
  endtask

  task automatic t_trig();
    logic [31:0] r;
    wr(1, 16'h4004, 32'h0004_0000);
    rd(0, 16'h4084, r); chk("R6 trig readback", r, 32'h0004_0000);
    unmask(50);
    chk("R6 R10 trig raises irq", 32'(irq), 32'h1);
    rd(0, 16'h2004, r); chk("R6 trig event line50", r, 32'h0001_0032);
    wr(0, 16'h4084, 32'h0004_0000);
    rd(0, 16'h4004, r); chk("R6 trig cleared", r, 32'h0);
    unmask(50);
    chk("R6 no pend after clear", 32'(irq), 32'h0);
    cleanup();
  endtask

  task automatic t_route();
    logic [31:0] r;
    wr(0, 16'h3000 + 16'd80, 32'h2);
    rd(1, 16'h3000 + 16'd80, r); chk("R7 route readback", r, 32'h2);
    hw_irq[20] = 1'b1;
    unmask(20);
    chk("R7 irq cpu1 only", 32'(irq), 32'h2);
    rd(0, 16'h2004, r); chk("R7 cpu0 sees none", r, 32'h0);
    rd(1, 16'h2004, r); chk("R7 cpu1 event line20", r, 32'h0001_0014);
    chk("R7 R4 irq cleared", 32'(irq), 32'h0);
    cleanup();
  endtask

  task automatic t_dual();
    logic [31:0] r0, r1;
    wr(0, 16'h3000 + 16'd16, 32'h3);
    wr(0, 16'h3000 + 16'd36, 32'h3);
    hw_irq[4] = 1'b1; hw_irq[9] = 1'b1;
    unmask(4); unmask(9);
    chk("R10 both irq", 32'(irq), 32'h3);
    @(negedge clk);
    req = 2'b11; we = 2'b00;
    addr = {16'h2004, 16'h2004};
    #1 r0 = rdata[31:0]; r1 = rdata[63:32];
    @(posedge clk);
    #1 req = '0;
    chk("R9 cpu0 wins line4", r0, 32'h0001_0004);
    chk("R9 cpu1 gets line9", r1, 32'h0001_0009);
    chk("R9 R4 both irq low", 32'(irq), 32'h0);
    rd(0, 16'h4100, r0); chk("R9 both masked", r0, 32'hFFFF_FFFF);
    cleanup();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_irq = '0; req = '0; we = '0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_ident();
    t_basic();
    t_mask();
    t_prio();
    t_trig();
    t_route();
    t_dual();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule